// File: doc/BRIEF.md
# Masked-Write Pin Function Select Bank

This block holds the function selection for a bank of 32 pins and presents a decoded function code for every pin. The pins form four groups of eight. Each group is given a field width at build time: 2, 3 or 4 bits per pin. A group can also be marked as fixed to GPIO or as unrouted. Software reaches the bank through a simple write port and a simple read port. Both ports take a byte address and carry 32-bit words.

Every write carries its own bit enables, so software never has to read a register before it changes one field. The upper half-word of the write data selects which bits of the lower half-word are taken. A 2-bit group fits in one register. A 3-bit or 4-bit group occupies two registers that follow each other. The 3-bit layout puts five pins in the first register and three in the second. The 4-bit layout puts four pins in each. The groups are packed one after another from a base address. The function codes drive the pad and peripheral selection logic downstream.

Top module: `pinmux_bank`

## Requirements
- R1: A write changes bit i (0..15) of the addressed register only when data bit i+16 is 1. Every other stored bit keeps its value.
- R2: In a 2-bit group, pin p of the group (p = pin mod 8) takes its function from bits [2p+1:2p] of the group's single register.
- R3: In a 3-bit group, pins p = 0..4 use bits [3p+2:3p] of the first register. Pins p = 5..7 use bits [3(p-5)+2:3(p-5)] of the second register. Register bits no field uses (bit 15 of the first, bits 15:9 of the second) read as 0.
- R4: In a 4-bit group, pins p = 0..3 use bits [4p+3:4p] of the first register. Pins p = 4..7 use bits [4(p-4)+3:4(p-4)] of the second register.
- R5: Groups are packed in order from BASE_ADDR. A 2-bit group takes 4 bytes and a 3-bit or 4-bit group takes 8. With the default parameters the registers are 0x00 (group 0, 2-bit), 0x04/0x08 (group 1, 3-bit), 0x0C/0x10 (group 2, 4-bit) and 0x14 (group 3, GPIO-fixed).
- R6: A group fixed to GPIO always reports function 0 on its pins and reads as 0. A write to it is accepted without error and changes nothing.
- R7: For an unrouted group, a read or a write to any of its addresses is rejected with an error and changes no state. Its pins report function 0.
- R8: A write to an address that is unmapped or not word-aligned raises wr_err in the cycle after the write, for one cycle, and changes no state. A read of such an address raises rd_err with rd_data equal to 0.
- R9: A read presented in one cycle is answered in the next cycle with rd_ack. The answer has rd_data[15:0] equal to the stored value and rd_data[31:16] equal to 0.
- R10: After reset every register holds 0, so every pin reports function 0.
- R11: A read of a register in the same cycle as a write to it returns the value from before the write. pin_func shows the written value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | 32 | [31:16] bit enables, [15:0] value |
| wr_err | output | 1 | One-cycle error pulse for a rejected write |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W (8) | Byte address of the read |
| rd_data | output | 32 | Read result, valid while rd_ack is high |
| rd_ack | output | 1 | Read response strobe |
| rd_err | output | 1 | The read was rejected, qualified by rd_ack |
| pin_func | output | 128 | 4-bit function code per pin, pin n at bits [4n+3:4n] |

## Verification
A write and a read can address the same register in the same clock cycle. The bench provokes this by raising wr_en and rd_en together on one address that holds a known value. The scoreboard expects the old value in the response. It then expects the new value on the pin outputs, and from a later read of the same register. A second instance, built with the last group unrouted, is used to judge that accesses there are rejected while the other groups still respond normally.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NGRP      = 4;
  localparam int PPG       = 8;
  localparam int NPINS     = NGRP * PPG;
  localparam int FUNC_W    = 4;
  localparam int HALF_W    = 16;
  localparam int GRP_IDX_W = $clog2(NGRP);

  typedef logic [NGRP*3-1:0] grp_width_t;
  typedef logic [NGRP-1:0]   grp_flag_t;

  function automatic int grp_w(grp_width_t gw, int g);
    return int'(gw[g*3 +: 3]);
  endfunction

  function automatic int grp_words(grp_width_t gw, int g);
    return (grp_w(gw, g) == 2) ? 1 : 2;
  endfunction

  function automatic int grp_base(grp_width_t gw, int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += grp_words(gw, i);
    return s;
  endfunction

  function automatic int total_words(grp_width_t gw);
    return grp_base(gw, NGRP);
  endfunction

  // bits of word k that hold a field; zero for fixed or unrouted groups
  function automatic logic [HALF_W-1:0] word_keep(grp_width_t gw, grp_flag_t gpio,
                                                  grp_flag_t unr, int k);
    logic [HALF_W-1:0] m;
    int b;
    m = '0;
    for (int g = 0; g < NGRP; g++) begin
      b = grp_base(gw, g);
      if (k >= b && k < b + grp_words(gw, g) && !gpio[g] && !unr[g]) begin
        if (grp_w(gw, g) == 3) m = (k == b) ? 16'h7FFF : 16'h01FF;
        else                   m = 16'hFFFF;
      end
    end
    return m;
  endfunction

  function automatic int pin_half(int w, int p);
    if (w == 2) return 0;
    if (w == 3) return (p >= 5) ? 1 : 0;
    return (p >= 4) ? 1 : 0;
  endfunction

  function automatic int pin_bit(int w, int p);
    if (w == 2) return p * 2;
    if (w == 3) return (p % 5) * 3;
    return (p % 4) * 4;
  endfunction
endpackage

// File: rtl/pinmux_addr_dec.sv
module pinmux_addr_dec
  import pinmux_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = '0,
  parameter grp_width_t        GRP_WIDTH    = {3'd2, 3'd4, 3'd3, 3'd2},
  parameter grp_flag_t         GRP_UNROUTED = '0,
  parameter int                WIDX_W       = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [WIDX_W-1:0]    widx,
  output logic [GRP_IDX_W-1:0] grp
);
  localparam int                NWORDS = total_words(GRP_WIDTH);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NWORDS * 4);

  logic [ADDR_W:0]   diff;
  logic [ADDR_W-1:0] off;
  logic              in_span;
  int                wi;

  always_comb begin
    diff    = {1'b0, addr} - {1'b0, BASE_ADDR};
    off     = diff[ADDR_W-1:0];
    in_span = !diff[ADDR_W] && (off < SPAN) && (off[1:0] == 2'b00);
    wi      = int'(off >> 2);
    grp     = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (wi >= grp_base(GRP_WIDTH, g) &&
          wi <  grp_base(GRP_WIDTH, g) + grp_words(GRP_WIDTH, g))
        grp = GRP_IDX_W'(g);
    end
    hit  = in_span && !GRP_UNROUTED[grp];
    widx = off[WIDX_W+1:2];
  end
endmodule

// File: rtl/pinmux_word.sv
module pinmux_word #(
  parameter logic [15:0] KEEP = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [15:0] q
);
  logic [15:0] en;
  logic [15:0] q_nxt;

  always_comb begin
    en    = wr_data[31:16] & KEEP;
    q_nxt = (q & ~en) | (wr_data[15:0] & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_sel) q <= q_nxt;
  end

  // R1
  hold_unenabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (((q ^ $past(q)) & ~$past(wr_data[31:16])) == 16'h0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(q));
endmodule

// File: rtl/pinmux_field_map.sv
module pinmux_field_map
  import pinmux_pkg::*;
#(
  parameter grp_width_t GRP_WIDTH     = {3'd2, 3'd4, 3'd3, 3'd2},
  parameter grp_flag_t  GRP_GPIO_ONLY = 4'b1000,
  parameter grp_flag_t  GRP_UNROUTED  = '0,
  parameter int         NWORDS        = 6
) (
  input  logic [NWORDS*HALF_W-1:0] words,
  output logic [NPINS*FUNC_W-1:0]  pin_func
);
  wire unused_words = ^words;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int W    = grp_w(GRP_WIDTH, g);
    localparam int BASE = grp_base(GRP_WIDTH, g);
    for (genvar p = 0; p < PPG; p++) begin : g_pin
      localparam int LSB = (BASE + pin_half(W, p)) * HALF_W + pin_bit(W, p);
      localparam int OUT = (g * PPG + p) * FUNC_W;
      if (GRP_GPIO_ONLY[g] || GRP_UNROUTED[g]) begin : g_fixed
        assign pin_func[OUT +: FUNC_W] = '0;
      end else if (W == 2) begin : g_w2
        assign pin_func[OUT +: FUNC_W] = {2'b00, words[LSB +: 2]};
      end else if (W == 3) begin : g_w3
        assign pin_func[OUT +: FUNC_W] = {1'b0, words[LSB +: 3]};
      end else begin : g_w4
        assign pin_func[OUT +: FUNC_W] = words[LSB +: 4];
      end
    end
  end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
  import pinmux_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR     = '0,
  parameter grp_width_t        GRP_WIDTH     = {3'd2, 3'd4, 3'd3, 3'd2},
  parameter grp_flag_t         GRP_GPIO_ONLY = 4'b1000,
  parameter grp_flag_t         GRP_UNROUTED  = 4'b0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [31:0]             wr_data,
  output logic                    wr_err,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [31:0]             rd_data,
  output logic                    rd_ack,
  output logic                    rd_err,
  output logic [NPINS*FUNC_W-1:0] pin_func
);
  localparam int NWORDS = total_words(GRP_WIDTH);
  localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // address decode, one per port
  logic                 w_hit, r_hit;
  logic [WIDX_W-1:0]    w_widx, r_widx;
  logic [GRP_IDX_W-1:0] w_grp, r_grp_unused;

  pinmux_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .GRP_WIDTH(GRP_WIDTH),
                    .GRP_UNROUTED(GRP_UNROUTED), .WIDX_W(WIDX_W))
    u_wdec (.addr(wr_addr), .hit(w_hit), .widx(w_widx), .grp(w_grp));

  pinmux_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .GRP_WIDTH(GRP_WIDTH),
                    .GRP_UNROUTED(GRP_UNROUTED), .WIDX_W(WIDX_W))
    u_rdec (.addr(rd_addr), .hit(r_hit), .widx(r_widx), .grp(r_grp_unused));

  // register words
  logic                     wr_ok;
  logic [NWORDS-1:0]        wr_sel;
  logic [HALF_W-1:0]        word_q [NWORDS];
  logic [NWORDS*HALF_W-1:0] words_flat;

  always_comb begin
    wr_ok = wr_en && w_hit && !GRP_GPIO_ONLY[w_grp];
    for (int k = 0; k < NWORDS; k++)
      wr_sel[k] = wr_ok && (int'(w_widx) == k);
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    pinmux_word #(.KEEP(word_keep(GRP_WIDTH, GRP_GPIO_ONLY, GRP_UNROUTED, k)))
      u_word (.clk(clk), .rst_n(rst_q), .wr_sel(wr_sel[k]), .wr_data(wr_data),
              .q(word_q[k]));
    assign words_flat[k*HALF_W +: HALF_W] = word_q[k];
  end

  pinmux_field_map #(.GRP_WIDTH(GRP_WIDTH), .GRP_GPIO_ONLY(GRP_GPIO_ONLY),
                     .GRP_UNROUTED(GRP_UNROUTED), .NWORDS(NWORDS))
    u_map (.words(words_flat), .pin_func(pin_func));

  // response next state
  logic [HALF_W-1:0] rd_word;
  logic [31:0]       rd_data_nxt;
  logic              rd_ack_nxt, rd_err_nxt, wr_err_nxt;

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NWORDS; k++)
      if (int'(r_widx) == k) rd_word = word_q[k];
    rd_data_nxt = (rd_en && r_hit) ? {16'h0000, rd_word} : 32'h0;
    rd_ack_nxt  = rd_en;
    rd_err_nxt  = rd_en && !r_hit;
    wr_err_nxt  = wr_en && !w_hit;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
      rd_err  <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      rd_data <= rd_data_nxt;
      rd_ack  <= rd_ack_nxt;
      rd_err  <= rd_err_nxt;
      wr_err  <= wr_err_nxt;
    end
  end

  // R8
  wr_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wr_err |-> $past(wr_en));

  // R8
  wr_err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wr_err |-> $stable(words_flat));

  // R8
  rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rd_err |-> (rd_ack && rd_data == 32'h0));

  // R9
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rd_ack |-> (rd_data[31:16] == 16'h0));

  // R6
  gpio_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && w_hit && GRP_GPIO_ONLY[w_grp]) |=> $stable(words_flat));
endmodule

// File: tb/pinmux_bank_tb.sv
`timescale 1ns/1ps
module pinmux_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   wr_addr = '0, rd_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         wr_err, rd_ack, rd_err;
  logic [31:0]  rd_data;
  logic [127:0] pin_func;

  logic         a_wr_en = 1'b0, a_rd_en = 1'b0;
  logic [7:0]   a_wr_addr = '0, a_rd_addr = '0;
  logic [31:0]  a_wr_data = '0;
  logic         a_wr_err, a_rd_ack, a_rd_err;
  logic [31:0]  a_rd_data;
  logic [127:0] a_pin_func;

  pinmux_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_err(wr_err), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ack(rd_ack), .rd_err(rd_err), .pin_func(pin_func));

  pinmux_bank #(.GRP_GPIO_ONLY(4'b0000), .GRP_UNROUTED(4'b1000)) u_alt (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data),
    .wr_err(a_wr_err), .rd_en(a_rd_en), .rd_addr(a_rd_addr), .rd_data(a_rd_data),
    .rd_ack(a_rd_ack), .rd_err(a_rd_err), .pin_func(a_pin_func));

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       req;
  } exp_t;
  exp_t sb[$];

  logic [15:0] mdl [6];
  localparam logic [15:0] KEEPM [6] =
    '{16'hFFFF, 16'h7FFF, 16'h01FF, 16'hFFFF, 16'hFFFF, 16'h0000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int a2i(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a >= 8'h18) return -1;
    return int'(a >> 2);
  endfunction

  // expected function per pin from the layout rules (R2, R3, R4, R6)
  function automatic logic [3:0] efn(input int pin);
    int p;
    p = pin % 8;
    case (pin / 8)
      0: return 4'((mdl[0] >> (p * 2)) & 16'h3);
      1: return (p < 5) ? 4'((mdl[1] >> (p * 3)) & 16'h7)
                        : 4'((mdl[2] >> ((p - 5) * 3)) & 16'h7);
      2: return (p < 4) ? 4'((mdl[3] >> (p * 4)) & 16'hF)
                        : 4'((mdl[4] >> ((p - 4) * 4)) & 16'hF);
      default: return 4'h0;
    endcase
  endfunction

  task automatic chk_pins(input string req);
    int bad_pin;
    bad_pin = -1;
    for (int n = 31; n >= 0; n--)
      if (pin_func[n*4 +: 4] !== efn(n)) bad_pin = n;
    n_chk++;
    if (bad_pin >= 0) begin
      n_bad++;
      $display("FAIL %s: pin %0d actual %h expected %h", req, bad_pin,
               pin_func[bad_pin*4 +: 4], efn(bad_pin));
    end
  endtask

  task automatic mdl_write(input int i, input logic [31:0] d);
    logic [15:0] e;
    if (i >= 0) begin
      e = d[31:16] & KEEPM[i];
      mdl[i] = (mdl[i] & ~e) | (d[15:0] & e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    int i;
    i = a2i(a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(req, 32'(wr_err), (i < 0) ? 32'd1 : 32'd0);
    mdl_write(i, d);
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    int i;
    exp_t e;
    i = a2i(a);
    e.req  = req;
    e.err  = (i < 0);
    e.data = (i < 0) ? 32'h0 : {16'h0, mdl[i]};
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    sb.push_back(e);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // write and read of one address in the same cycle
  task automatic wr_rd(input logic [7:0] a, input logic [31:0] d, input string req);
    int i;
    exp_t e;
    i = a2i(a);
    e.req  = req;
    e.err  = 1'b0;
    e.data = {16'h0, mdl[i]};
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    rd_en = 1'b1; rd_addr = a;
    sb.push_back(e);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(req, 32'(wr_err), 32'd0);
    mdl_write(i, d);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rd_ack) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: response without request actual %h expected none", rd_data);
      end else begin
        e = sb.pop_front();
        chk(e.req, rd_data, e.data);
        chk(e.req, 32'(rd_err), 32'(e.err));
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < 6; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    chk("R10", pin_func[31:0], 32'h0);
    chk("R10", {31'h0, wr_err | rd_ack}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 every register cleared
    for (int k = 0; k < 6; k++) rd(8'(k * 4), "R10");
    chk_pins("R10");

    // R2 2-bit group
    wr(8'h00, 32'hFFFF_A5C3, "R2");
    rd(8'h00, "R2");
    chk_pins("R2");
    chk("R2", 32'(pin_func[3:0]), 32'h3);
    chk("R2", 32'(pin_func[31:28]), 32'h2);

    // R1 bit enables
    wr(8'h00, 32'h00F0_0F5A, "R1");
    rd(8'h00, "R1");
    wr(8'h00, 32'h0000_FFFF, "R1");
    rd(8'h00, "R1");
    wr(8'h00, 32'h8001_0000, "R1");
    rd(8'h00, "R1");
    chk_pins("R1");

    // R3 3-bit group split 5/3
    wr(8'h04, 32'hFFFF_FFFF, "R3");
    wr(8'h08, 32'hFFFF_FFFF, "R3");
    rd(8'h04, "R3");
    rd(8'h08, "R3");
    chk_pins("R3");
    wr(8'h04, 32'hFFFF_4C5A, "R3");
    wr(8'h08, 32'hFFFF_0123, "R3");
    rd(8'h08, "R3");
    chk_pins("R3");
    chk("R3", 32'(pin_func[12*4 +: 4]), 32'h4);
    chk("R3", 32'(pin_func[13*4 +: 4]), 32'h3);
    chk("R3", 32'(pin_func[15*4 +: 4]), 32'h4);

    // R4 4-bit group split 4/4
    wr(8'h0C, 32'hFFFF_1234, "R4");
    wr(8'h10, 32'hFFFF_ABCD, "R4");
    chk_pins("R4");
    chk("R4", 32'(pin_func[16*4 +: 4]), 32'h4);
    chk("R4", 32'(pin_func[20*4 +: 4]), 32'hD);
    chk("R4", 32'(pin_func[23*4 +: 4]), 32'hA);

    // R5 packed address map
    rd(8'h0C, "R5");
    rd(8'h10, "R5");
    rd(8'h04, "R5");

    // R6 GPIO-fixed group
    wr(8'h14, 32'hFFFF_FFFF, "R6");
    rd(8'h14, "R6");
    chk("R6", pin_func[127:96], 32'h0);

    // R8 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF, "R8");
    @(negedge clk);
    chk("R8", 32'(wr_err), 32'd0);
    wr(8'h02, 32'hFFFF_0000, "R8");
    wr(8'hF0, 32'hFFFF_0000, "R8");
    rd(8'h18, "R8");
    rd(8'h01, "R8");
    for (int k = 0; k < 6; k++) rd(8'(k * 4), "R8");
    chk_pins("R8");

    // R11 same-cycle write and read
    wr_rd(8'h0C, 32'hFFFF_0000, "R11");
    chk_pins("R11");
    rd(8'h0C, "R11");

    // R7 unrouted group on the alternate build
    @(negedge clk);
    a_wr_en = 1'b1; a_wr_addr = 8'h14; a_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    a_wr_en = 1'b0;
    chk("R7", 32'(a_wr_err), 32'd1);
    a_rd_en = 1'b1; a_rd_addr = 8'h14;
    @(negedge clk);
    a_rd_en = 1'b0;
    chk("R7", {30'h0, a_rd_ack, a_rd_err}, 32'h3);
    chk("R7", a_rd_data, 32'h0);
    chk("R7", a_pin_func[127:96], 32'h0);
    a_wr_en = 1'b1; a_wr_addr = 8'h00; a_wr_data = 32'hFFFF_0003;
    @(negedge clk);
    a_wr_en = 1'b0;
    chk("R7", 32'(a_wr_err), 32'd0);
    chk("R7", 32'(a_pin_func[3:0]), 32'h3);

    repeat (4) @(negedge clk);
    chk("R9", 32'(sb.size()), 32'd0);
    summary();
  end
endmodule